// File: doc/BRIEF.md
# Link Speed Downshift Controller

This controller supervises bring-up of a backplane link. After a start strobe it asks the negotiation logic to restart the link while the full set of speeds is advertised. It then samples the link-status input on a slow poll tick, several times per attempt. If no link appears after a parameterised number of such attempts, and the capabilities allow it, the controller withdraws the top rate from the advertisement. It restarts once more and watches a longer window, because lower-rate links need time for fail-inhibit timers and repeated parallel detection.

If that extended attempt also fails, the withdrawal is undone, so that the next bring-up starts from the full advertisement again. If the top rate is not supported, or none of the lower parallel rates is, no downshift is tried at all. An abort input ends any run at once and leaves the advertisement intact. The negotiation machinery itself and all other register programming stay outside this block. It only drives the restart strobe and the downshift control.

Top module: `link_downshift_ctrl`

## Requirements
- R1: After reset, restart_o, downshift_o, busy_o, done_o and link_found_o are all 0.
- R2: A start_i sampled while busy_o is 0 gives, on the next cycle, busy_o=1, done_o=0, link_found_o=0, downshift_o=0, and a restart_o pulse that lasts exactly one cycle.
- R3: While busy, link_up_i is sampled once every TICK_CYCLES cycles, counted from the start edge. The first sample that reads 1 ends the run on the next cycle with done_o=1, link_found_o=1 and busy_o=0.
- R4: Each full-advertisement attempt takes POLLS_FULL samples (default 5). When all of them fail and fewer than RETRY_MAX attempts (default 2) have been made, restart_o pulses on the cycle after the last sample of that attempt.
- R5: When the last sample of the last full attempt fails and either cap_top_i=0 or cap_lower_i is all zeros, the run ends with done_o=1, link_found_o=0, downshift_o=0 and no restart pulse.
- R6: When that last sample fails and cap_top_i=1 with at least one cap_lower_i bit set, downshift_o rises together with a restart_o pulse, and busy_o stays 1.
- R7: In downshift mode, POLLS_DOWN samples (default 6) are taken at the same interval. A sample that reads 1 ends the run with link_found_o=1, and downshift_o stays 1.
- R8: If all downshift samples fail, the run ends with downshift_o=0, done_o=1 and link_found_o=0.
- R9: abort_i sampled while busy ends the run on the next cycle with done_o=1, busy_o=0, downshift_o=0 and link_found_o=0. This holds even if a link-up sample falls on the same edge. abort_i while idle changes no output.
- R10: start_i while busy is ignored: no restart pulse, and the run keeps its timing.
- R11: done_o and link_found_o hold until the next accepted start. An accepted start clears downshift_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up run |
| abort_i | input | 1 | End the current run at once |
| cap_top_i | input | 1 | Top rate is supported |
| cap_lower_i | input | N_LOWER | Lower parallel rates supported, one bit each |
| link_up_i | input | 1 | Link status from negotiation logic |
| restart_o | output | 1 | One-cycle link restart request |
| downshift_o | output | 1 | Withdraw the top rate from the advertisement |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| link_found_o | output | 1 | The run ended with link up |

## Verification
The abort path and the poll path can act on the same edge: an abort may arrive exactly when a link-up sample is due. The bench provokes this by raising abort_i and link_up_i together for the edge of the second poll. It expects the abort to win, with link_found_o=0 and downshift_o cleared. A second overlap is a start strobe inside a run. It is applied a few cycles after an accepted start and is judged by the absence of a restart pulse and by the unchanged cycle in which the run completes.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FULL = 2'd1,
    PH_DOWN = 2'd2
  } phase_t;
endpackage

// File: rtl/ldc_tick_gen.sv
module ldc_tick_gen #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == W'(N - 1));
  assign tick   = at_end && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ldc_step_ctr.sv
module ldc_step_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ldc_cap_check.sv
module ldc_cap_check #(
  parameter int N_LOWER = 2
) (
  input  logic               cap_top,
  input  logic [N_LOWER-1:0] cap_lower,
  output logic               may_downshift
);
  logic [N_LOWER:0] any_chain;
  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < N_LOWER; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | cap_lower[g];
  end
  assign may_downshift = cap_top & any_chain[N_LOWER];
endmodule

// File: rtl/link_downshift_ctrl.sv
module link_downshift_ctrl
  import ldc_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int RETRY_MAX   = 2,
  parameter int POLLS_FULL  = 5,
  parameter int POLLS_DOWN  = 6,
  parameter int N_LOWER     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               cap_top_i,
  input  logic [N_LOWER-1:0] cap_lower_i,
  input  logic               link_up_i,
  output logic               restart_o,
  output logic               downshift_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               link_found_o
);
  localparam int POLL_MAX = (POLLS_FULL > POLLS_DOWN) ? POLLS_FULL : POLLS_DOWN;
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int RW       = $clog2(RETRY_MAX + 1);

  phase_t       phase_q;
  logic         restart_q, ds_q, busy_q, done_q, found_q;
  logic         tick, in_idle, poll_last, retry_last, cap_ok;
  logic [PW-1:0] poll_cnt, poll_lim;
  logic [RW-1:0] retry_cnt;

  assign in_idle = (phase_q == PH_IDLE);

  ldc_tick_gen #(.N(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .clr(in_idle), .tick(tick)
  );

  ldc_step_ctr #(.W(PW)) u_polls (
    .clk(clk), .rst(rst),
    .clr(in_idle || (tick && poll_last)),
    .inc(tick),
    .cnt(poll_cnt)
  );

  ldc_step_ctr #(.W(RW)) u_retries (
    .clk(clk), .rst(rst),
    .clr(in_idle),
    .inc(tick && poll_last && (phase_q == PH_FULL)),
    .cnt(retry_cnt)
  );

  ldc_cap_check #(.N_LOWER(N_LOWER)) u_caps (
    .cap_top(cap_top_i), .cap_lower(cap_lower_i), .may_downshift(cap_ok)
  );

  assign poll_lim   = (phase_q == PH_DOWN) ? PW'(POLLS_DOWN - 1) : PW'(POLLS_FULL - 1);
  assign poll_last  = (poll_cnt == poll_lim);
  assign retry_last = (retry_cnt == RW'(RETRY_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      restart_q <= 1'b0;
      ds_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      found_q   <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q   <= PH_FULL;
            restart_q <= 1'b1;
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
            found_q   <= 1'b0;
            ds_q      <= 1'b0;
          end
        end
        PH_FULL, PH_DOWN: begin
          if (abort_i) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            found_q <= 1'b0;
            ds_q    <= 1'b0;
          end else if (tick) begin
            if (link_up_i) begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              found_q <= 1'b1;
            end else if (poll_last) begin
              if (phase_q == PH_DOWN) begin
                phase_q <= PH_IDLE;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                ds_q    <= 1'b0;
              end else if (!retry_last) begin
                restart_q <= 1'b1;
              end else if (cap_ok) begin
                phase_q   <= PH_DOWN;
                ds_q      <= 1'b1;
                restart_q <= 1'b1;
              end else begin
                phase_q <= PH_IDLE;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign restart_o    = restart_q;
  assign downshift_o  = ds_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign link_found_o = found_q;
endmodule

// File: rtl/link_downshift_ctrl_chk.sv
module link_downshift_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic abort_i,
  input logic restart_o,
  input logic downshift_o,
  input logic busy_o,
  input logic done_o,
  input logic link_found_o
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && restart_o && !done_o && !link_found_o));

  // R2
  restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  // R6
  ds_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(downshift_o) |-> (restart_o && busy_o));

  // R8
  ds_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(downshift_o) |-> (done_o || restart_o));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && abort_i) |=> (done_o && !busy_o && !downshift_o && !link_found_o));

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R3
  found_done_chk: assert property (@(posedge clk) disable iff (rst)
    link_found_o |-> done_o);
endmodule

bind link_downshift_ctrl link_downshift_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
  .restart_o(restart_o), .downshift_o(downshift_o), .busy_o(busy_o),
  .done_o(done_o), .link_found_o(link_found_o)
);

// File: tb/tb_link_downshift_ctrl.sv
module tb_link_downshift_ctrl;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, abort_i = 1'b0, cap_top_i = 1'b0, link_up_i = 1'b0;
  logic [1:0] cap_lower_i = 2'b00;
  logic restart_o, downshift_o, busy_o, done_o, link_found_o;

  int cyc = 0;
  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  typedef struct {
    int         c;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_downshift_ctrl #(.TICK_CYCLES(T)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
    .cap_top_i(cap_top_i), .cap_lower_i(cap_lower_i), .link_up_i(link_up_i),
    .restart_o(restart_o), .downshift_o(downshift_o), .busy_o(busy_o),
    .done_o(done_o), .link_found_o(link_found_o)
  );

  // Monitor: bit order {restart, downshift, busy, done, found}
  always @(negedge clk) begin
    logic [4:0] act;
    act = {restart_o, downshift_o, busy_o, done_o, link_found_o};
    while (sb.size() > 0 && sb[0].c <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (e.c < cyc) begin
        misses++;
        $display("FAIL %s cycle %0d missed: actual %b expected %b", e.tag, e.c, act, e.v);
      end else if (act !== e.v) begin
        misses++;
        $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, e.c, act, e.v);
      end
    end
  end

  task automatic expect_at(input int c, input logic [4:0] v, input string tag);
    exp_t e;
    e.c = c; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // Returns at the negedge just before edge e
  task automatic pre_edge(input int e);
    while (cyc < e - 1) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 40000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int e0, e1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_at(cyc + 1, 5'b00000, "R1");
    expect_at(cyc + 2, 5'b00000, "R1");
    drain();

    // Scenario A: link on third poll of first attempt; stray start inside run
    e0 = cyc + 1;
    expect_at(e0,           5'b10100, "R2");
    expect_at(e0 + 1,       5'b00100, "R2");
    expect_at(e0 + 6,       5'b00100, "R10");
    expect_at(e0 + 3*T - 1, 5'b00100, "R3");
    expect_at(e0 + 3*T,     5'b00011, "R3");
    expect_at(e0 + 3*T + 2, 5'b00011, "R11");
    pulse_start();
    pre_edge(e0 + 5); pulse_start();
    pre_edge(e0 + 3*T); link_up_i = 1'b1;
    @(negedge clk); link_up_i = 1'b0;
    drain();

    // Scenario B: retries exhausted, no lower rate -> no downshift
    cap_top_i = 1'b1; cap_lower_i = 2'b00;
    e0 = cyc + 1;
    expect_at(e0 + 5*T - 1,  5'b00100, "R4");
    expect_at(e0 + 5*T,      5'b10100, "R4");
    expect_at(e0 + 5*T + 1,  5'b00100, "R4");
    expect_at(e0 + 10*T,     5'b00010, "R5");
    expect_at(e0 + 10*T + 1, 5'b00010, "R5");
    pulse_start();
    drain();

    // Scenario E: top rate unsupported
    cap_top_i = 1'b0; cap_lower_i = 2'b11;
    e0 = cyc + 1;
    expect_at(e0 + 10*T, 5'b00010, "R5");
    pulse_start();
    drain();

    // Scenario C: downshift window fails, advertisement restored
    cap_top_i = 1'b1; cap_lower_i = 2'b10;
    e0 = cyc + 1;
    expect_at(e0 + 10*T,     5'b11100, "R6");
    expect_at(e0 + 10*T + 1, 5'b01100, "R6");
    expect_at(e0 + 16*T - 1, 5'b01100, "R8");
    expect_at(e0 + 16*T,     5'b00010, "R8");
    pulse_start();
    drain();

    // Scenario D: link in downshift window, then restart clears it, then abort
    cap_lower_i = 2'b01;
    e0 = cyc + 1;
    expect_at(e0 + 14*T,     5'b01011, "R7");
    expect_at(e0 + 14*T + 2, 5'b01011, "R7");
    pulse_start();
    pre_edge(e0 + 14*T); link_up_i = 1'b1;
    @(negedge clk); link_up_i = 1'b0;
    drain();
    e1 = cyc + 1;
    expect_at(e1,     5'b10100, "R11");
    expect_at(e1 + 2, 5'b00010, "R9");
    pulse_start();
    pre_edge(e1 + 2); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    drain();

    // Scenario F: abort and link-up sample on the same edge
    e0 = cyc + 1;
    expect_at(e0 + 2*T,     5'b00010, "R9");
    expect_at(e0 + 2*T + 1, 5'b00010, "R9");
    pulse_start();
    pre_edge(e0 + 2*T); abort_i = 1'b1; link_up_i = 1'b1;
    @(negedge clk); abort_i = 1'b0; link_up_i = 1'b0;
    drain();

    // Scenario G: abort during downshift window, then abort while idle
    e0 = cyc + 1;
    expect_at(e0 + 10*T, 5'b11100, "R6");
    expect_at(e0 + 12*T, 5'b00010, "R9");
    pulse_start();
    pre_edge(e0 + 12*T); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    drain();
    e1 = cyc + 1;
    expect_at(e1,     5'b00010, "R9");
    expect_at(e1 + 1, 5'b00010, "R9");
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    drain();

    summary();
  end
endmodule